// File: doc/BRIEF.md
# Feedback-Driven Cascade Supply Sequencer

This block brings up to nine supply rails up and down in an order set by software. Each rail has an enable output toward its converter and a power-good input back from it. Software gives each rail one of eight sequence slots. On a start command the slots are stepped through from lowest to highest. Every rail in a slot is enabled together. The next slot opens only once all rails of the current slot report power-good. A stop command walks the slots from highest to lowest, waiting in each slot for its rails to drop power-good.

Settings arrive on a simple parallel write port. A rail can leave the sequence in two ways: software forces it on or off, or it follows one of two external enable pins. An input-undervoltage lockout keeps a start command from taking effect. The rails must reach power-good within a programmable number of cycles, or the sequence aborts into a fault. An external fault input either runs an orderly stop or cuts every rail at once, as software chooses. A status output reports the state and the current slot.

Top module: `cascade_seq`

## Requirements
- R1: After reset every enable is low, the state reads idle (0), the slot reads 0 and the sequence-fault flag is low.
- R2: A write to address 0xF with bit 0 set starts the sequence. The channel register at address i holds the slot of channel i in bits [2:0]. Slots open in ascending order, and every channel of a slot enables in the same cycle. A slot opens one cycle after every channel of the previous occupied slot shows power-good.
- R3: A slot with no sequenced channel costs exactly one cycle and does not wait.
- R4: A write to 0xF with bit 1 set starts the stop. Slots close in descending order. The next lower slot closes one cycle after every channel of the current slot has dropped power-good. If that does not happen, it closes one cycle after the timeout count held at address 0xE has expired.
- R5: In a channel register, bit 6 forces that enable high and bit 5 forces it low (bit 6 wins). Either one takes the channel out of the sequence, so the sequence neither drives it nor waits on it.
- R6: In a channel register, bit 3 ties that enable to an external pin instead of the sequence. Bit 4 selects the pin: 0 for ext_en[0], 1 for ext_en[1].
- R7: While uvlo is high, a start command is ignored and the block stays idle.
- R8: During start, if a slot has not reached power-good when the timeout count at 0xE runs out, the block enters fault (4). It raises seq_fault and drops every enable.
- R9: fault_in in the starting, on or stopping state does one of two things, chosen by bit 2 of the last write to 0xF. With 0, all enables drop in the next cycle. With 1, an orderly stop runs and ends in fault.
- R10: In fault, a stop command returns the block to idle and clears seq_fault.
- R11: st_state encodes idle 0, starting 1, on 2, stopping 3 and fault 4. st_pos gives the slot being worked on, and reads 7 while on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address: channel 0..NCH-1, 0xE timeout, 0xF command |
| cfg_wdata | input | 8 | Register write data |
| pgood | input | NCH | Power-good feedback per channel |
| ext_en | input | 2 | External enable pins |
| fault_in | input | 1 | External fault request |
| uvlo | input | 1 | Input undervoltage lockout active |
| en | output | NCH | Converter enable per channel |
| st_state | output | 3 | Sequencer state code |
| st_pos | output | 3 | Current sequence slot |
| seq_fault | output | 1 | Power-up timeout flag |

## Verification
The cases hardest to reach are the stop-side timeout and the start-side abort, since both need a rail whose power-good disobeys its enable. The bench models each converter as a fixed-latency follower of its enable. It can pin any one channel's power-good stuck high or stuck low. It then measures the exact cycle gap between slots in both directions. Sparse slot assignments with gaps exercise the skip of empty slots inside the same runs.

// File: rtl/cascade_seq.sv
module cascade_seq #(
  parameter int NCH = 9,
  parameter int TW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [3:0]     cfg_addr,
  input  logic [7:0]     cfg_wdata,
  input  logic [NCH-1:0] pgood,
  input  logic [1:0]     ext_en,
  input  logic           fault_in,
  input  logic           uvlo,
  output logic [NCH-1:0] en,
  output logic [2:0]     st_state,
  output logic [2:0]     st_pos,
  output logic           seq_fault
);
  localparam logic [3:0] A_TMO = 4'hE;
  localparam logic [3:0] A_CTL = 4'hF;
  localparam logic [2:0] TOP   = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_UP, S_ON, S_DOWN, S_FLT} st_t;

  st_t            st;
  logic [2:0]     pos;
  logic [TW-1:0]  tmr, tmo;
  logic           f_act, fault_pend;
  logic [2:0]     slot  [NCH];
  logic [1:0]     ovr   [NCH];
  logic [NCH-1:0] map_en, map_sel, member, in_grp, seq_en;

  wire ctl_wr  = cfg_we && cfg_addr == A_CTL;
  wire up_req  = ctl_wr && cfg_wdata[0];
  wire dn_req  = ctl_wr && cfg_wdata[1];
  wire grp_any = |in_grp;
  wire grp_up  = &(~in_grp | pgood);
  wire grp_dn  = ~|(in_grp & pgood);
  wire tmo_hit = tmr == tmo;

  assign st_state = st;
  assign st_pos   = pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo   <= TW'(32);
      f_act <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        slot[i]    <= '0;
        ovr[i]     <= '0;
        map_en[i]  <= 1'b0;
        map_sel[i] <= 1'b0;
      end
    end else if (cfg_we) begin
      if (cfg_addr == A_TMO) tmo <= TW'(cfg_wdata);
      if (ctl_wr) f_act <= cfg_wdata[2];
      for (int i = 0; i < NCH; i++)
        if (cfg_addr == 4'(i)) begin
          slot[i]    <= cfg_wdata[2:0];
          map_en[i]  <= cfg_wdata[3];
          map_sel[i] <= cfg_wdata[4];
          ovr[i]     <= cfg_wdata[6:5];
        end
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      member[i] = ovr[i] == 2'b00 && !map_en[i];
      in_grp[i] = member[i] && slot[i] == pos;
      case (st)
        S_ON:    seq_en[i] = member[i];
        S_UP:    seq_en[i] = member[i] && slot[i] <= pos;
        S_DOWN:  seq_en[i] = member[i] && slot[i] < pos;
        default: seq_en[i] = 1'b0;
      endcase
      if (st == S_FLT)    en[i] = 1'b0;
      else if (ovr[i][1]) en[i] = 1'b1;
      else if (ovr[i][0]) en[i] = 1'b0;
      else if (map_en[i]) en[i] = ext_en[map_sel[i]];
      else                en[i] = seq_en[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pos        <= '0;
      tmr        <= '0;
      seq_fault  <= 1'b0;
      fault_pend <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (up_req && !uvlo) begin
          st  <= S_UP;
          pos <= '0;
          tmr <= '0;
        end
        S_UP: begin
          tmr <= tmr + 1'b1;
          if (fault_in) begin
            tmr <= '0;
            if (f_act) begin
              st         <= S_DOWN;
              fault_pend <= 1'b1;
            end else st <= S_FLT;
          end else if (dn_req) begin
            st  <= S_DOWN;
            tmr <= '0;
          end else if (!grp_any || grp_up) begin
            tmr <= '0;
            if (pos == TOP) st <= S_ON;
            else pos <= pos + 1'b1;
          end else if (tmo_hit) begin
            st        <= S_FLT;
            seq_fault <= 1'b1;
          end
        end
        S_ON: if (fault_in || dn_req) begin
          tmr <= '0;
          pos <= TOP;
          if (fault_in && !f_act) st <= S_FLT;
          else begin
            st <= S_DOWN;
            if (fault_in) fault_pend <= 1'b1;
          end
        end
        S_DOWN: begin
          tmr <= tmr + 1'b1;
          if (fault_in && !f_act) st <= S_FLT;
          else begin
            if (fault_in) fault_pend <= 1'b1;
            if (!grp_any || grp_dn || tmo_hit) begin
              tmr <= '0;
              if (pos == '0) st <= (fault_pend || fault_in) ? S_FLT : S_IDLE;
              else pos <= pos - 1'b1;
            end
          end
        end
        default: if (dn_req) begin
          st         <= S_IDLE;
          pos        <= '0;
          seq_fault  <= 1'b0;
          fault_pend <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cascade_seq_chk.sv
module cascade_seq_chk #(
  parameter int NCH = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] en,
  input logic [2:0]     st_state,
  input logic [2:0]     st_pos,
  input logic           seq_fault,
  input logic           uvlo,
  input logic           fault_in,
  input logic           f_act
);
  p_fault_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_state == 3'd4 |-> en == '0);

  p_uvlo_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_state == 3'd0 && uvlo) |=> st_state == 3'd0);

  p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_state == 3'd1 |=> (st_state != 3'd1 || st_pos == $past(st_pos)
                          || st_pos == $past(st_pos) + 3'd1));

  p_down_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_state == 3'd3 |=> (st_state != 3'd3 || st_pos == $past(st_pos)
                          || st_pos == $past(st_pos) - 3'd1));

  p_flag_in_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fault |-> st_state == 3'd4);

  p_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in && !f_act && st_state inside {3'd1, 3'd2, 3'd3}) |=> st_state == 3'd4);
endmodule

bind cascade_seq cascade_seq_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .st_state(st_state), .st_pos(st_pos),
  .seq_fault(seq_fault), .uvlo(uvlo), .fault_in(fault_in), .f_act(f_act)
);

// File: tb/cascade_seq_tb_top.sv
module cascade_seq_tb_top;
  localparam int NCH = 9;
  localparam int LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [NCH-1:0] pgood, en;
  logic [1:0] ext_en = '0;
  logic fault_in = 1'b0, uvlo = 1'b0;
  logic [2:0] st_state, st_pos;
  logic seq_fault;

  logic [NCH-1:0] stuck_lo = '0, stuck_hi = '0, prev_en = '0;
  logic [LAT-1:0] hist [NCH];
  int slot_tb [NCH] = '{2, 0, 5, 2, 0, 7, 5, 2, 0};
  int t_on [NCH], t_off [NCH];
  int cyc = 0, checks = 0, errors = 0;
  bit fact = 1'b0;

  always #4 clk = ~clk;

  cascade_seq #(.NCH(NCH), .TW(8)) dut_i (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < NCH; i++) hist[i] <= {hist[i][LAT-2:0], en[i]};
  end

  always_comb
    for (int i = 0; i < NCH; i++)
      pgood[i] = stuck_lo[i] ? 1'b0 : stuck_hi[i] ? 1'b1 : hist[i][LAT-1];

  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (en[i] && !prev_en[i] && t_on[i] < 0) t_on[i] = cyc;
      if (!en[i] && prev_en[i] && t_off[i] < 0) t_off[i] = cyc;
    end
    prev_en = en;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cmd(bit up, bit dn);
    wr(4'hF, {5'd0, fact, dn, up});
  endtask

  task automatic clear_times();
    for (int i = 0; i < NCH; i++) begin t_on[i] = -1; t_off[i] = -1; end
  endtask

  task automatic wait_state(int s, int lim);
    for (int k = 0; k < lim && st_state != 3'(s); k++) @(negedge clk);
  endtask

  task automatic cfg_all();
    for (int i = 0; i < NCH; i++) wr(4'(i), 8'(slot_tb[i]));
  endtask

  task automatic t_reset();
    chk(en == '0, "R1 enables", int'(en), 0);
    chk(st_state == 0, "R1 state", st_state, 0);
    chk(st_pos == 0, "R1 slot", st_pos, 0);
    chk(seq_fault == 0, "R1 flag", seq_fault, 0);
  endtask

  task automatic t_up_order();
    int exp, base, last;
    clear_times();
    cmd(1, 0);
    chk(st_state == 1, "R11 starting code", st_state, 1);
    wait_state(2, 200);
    chk(st_state == 2, "R11 on code", st_state, 2);
    chk(st_pos == 7, "R11 slot while on", st_pos, 7);
    base = t_on[1]; exp = 0; last = 0;
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < NCH; i++)
        if (slot_tb[i] == s) begin
          if (s != last) begin exp += LAT + 1 + (s - last - 1); last = s; end
          chk(t_on[i] - base == exp, "R2/R3 rise cycle", t_on[i] - base, exp);
        end
  endtask

  task automatic t_down_order();
    int exp, last;
    clear_times();
    cmd(0, 1);
    chk(st_state == 3, "R11 stopping code", st_state, 3);
    wait_state(0, 200);
    chk(st_state == 0 && en == '0, "R4 idle after stop", st_state, 0);
    exp = 0; last = 7;
    for (int s = 7; s >= 0; s--)
      for (int i = 0; i < NCH; i++)
        if (slot_tb[i] == s) begin
          if (s != last) begin exp += LAT + 1 + (last - s - 1); last = s; end
          chk(t_off[i] - t_off[5] == exp, "R4 fall cycle", t_off[i] - t_off[5], exp);
        end
  endtask

  task automatic t_down_timeout();
    wr(4'hE, 8'd10);
    cmd(1, 0);
    wait_state(2, 200);
    stuck_hi[5] = 1'b1;
    clear_times();
    cmd(0, 1);
    wait_state(0, 200);
    chk(t_off[2] - t_off[5] == 12, "R4 stop timeout gap", t_off[2] - t_off[5], 12);
    stuck_hi[5] = 1'b0;
    repeat (LAT + 1) @(negedge clk);
  endtask

  task automatic t_override();
    wr(4'd1, 8'h40);
    chk(en[1] == 1 && st_state == 0, "R5 force on in idle", en[1], 1);
    wr(4'd1, 8'(slot_tb[1]));
    chk(en[1] == 0, "R5 release", en[1], 0);
    cmd(1, 0);
    wait_state(2, 200);
    wr(4'd0, 8'h22);
    chk(en[0] == 0 && st_state == 2, "R5 force off while on", en[0], 0);
    wr(4'd0, 8'(slot_tb[0]));
    chk(en[0] == 1, "R5 back to sequence", en[0], 1);
    cmd(0, 1);
    wait_state(0, 200);
  endtask

  task automatic t_pins();
    wr(4'd8, 8'h18);
    ext_en = 2'b10; @(negedge clk);
    chk(en[8] == 1, "R6 pin 1 high", en[8], 1);
    ext_en = 2'b01; @(negedge clk);
    chk(en[8] == 0, "R6 pin 1 low", en[8], 0);
    wr(4'd8, 8'h08);
    chk(en[8] == 1, "R6 pin 0 high", en[8], 1);
    ext_en = 2'b00;
    wr(4'd8, 8'(slot_tb[8]));
  endtask

  task automatic t_uvlo();
    uvlo = 1'b1;
    cmd(1, 0);
    repeat (5) @(negedge clk);
    chk(st_state == 0 && en == '0, "R7 start blocked", st_state, 0);
    uvlo = 1'b0;
  endtask

  task automatic t_up_timeout();
    stuck_lo[1] = 1'b1;
    cmd(1, 0);
    repeat (8) @(negedge clk);
    chk(st_state == 1 && st_pos == 0, "R8 still waiting", st_state, 1);
    repeat (4) @(negedge clk);
    chk(st_state == 4, "R8 fault state", st_state, 4);
    chk(seq_fault == 1, "R8 flag", seq_fault, 1);
    chk(en == '0, "R8 all off", int'(en), 0);
    stuck_lo[1] = 1'b0;
    cmd(1, 0);
    chk(st_state == 4, "R10 start ignored in fault", st_state, 4);
    cmd(0, 1);
    chk(st_state == 0 && seq_fault == 0, "R10 cleared", seq_fault, 0);
  endtask

  task automatic t_fault_cut();
    fact = 1'b0;
    cmd(1, 0);
    wait_state(2, 200);
    fault_in = 1'b1; @(negedge clk); fault_in = 1'b0;
    chk(st_state == 4 && en == '0, "R9 immediate cut", int'(en), 0);
    cmd(0, 1);
    repeat (LAT + 1) @(negedge clk);
  endtask

  task automatic t_fault_ordered();
    fact = 1'b1;
    cmd(1, 0);
    wait_state(2, 200);
    fault_in = 1'b1; @(negedge clk); fault_in = 1'b0;
    chk(st_state == 3, "R9 ordered stop entered", st_state, 3);
    chk(en[5] == 0 && en[1] == 1, "R9 top slot off first", en[1], 1);
    wait_state(4, 200);
    chk(st_state == 4 && en == '0, "R9 ordered stop ends in fault", st_state, 4);
    fact = 1'b0;
    cmd(0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_times();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    cfg_all();
    t_up_order();
    t_down_order();
    t_down_timeout();
    t_override();
    t_pins();
    t_uvlo();
    t_up_timeout();
    t_fault_cut();
    t_fault_ordered();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule